// File: doc/BRIEF.md
# Microcontroller Power-Mode Sequencer

This block tracks the operating mode of a small microcontroller. It decides which low-power mode to enter when the CPU runs a sleep instruction, which events bring the part back out of that mode, and how the hardware-standby and reset pins override whatever mode is current. The inputs are the configuration that software has written: a standby-select bit, a clock-divide field, and the module-stop masks.

The two pins pass through a two-flop synchroniser. The standby pin wins over the reset pin, and hardware standby can only be left through the reset state. When the CPU is running, the clock-divide field chooses between high-speed and divided-clock execution. A sleep strobe goes to one of three modes, chosen from the standby bit and from whether every module is stopped. Each of the three modes has its own set of wake events.

The outputs are:
- a one-hot mode vector,
- a CPU halt,
- a module clock enable,
- a register-reset request,
- a one-cycle wake pulse that starts exception handling.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A low level on `stby_n_i` reaches hardware standby from any mode three clocks later (two synchroniser stages plus the state register). It wins when `res_n_i` falls in the same cycle.
- R2: A low level on `res_n_i` reaches the reset state three clocks later from any mode except hardware standby.
- R3: Hardware standby is left only when `stby_n_i` is high and `res_n_i` is low, and it then goes to the reset state. With both pins high it stays in hardware standby.
- R4: The reset state moves to execution one clock after the synchronised reset pin is high. In execution, `sck_i == 0` selects high-speed mode and any nonzero value selects divided-clock mode. A change of `sck_i` switches between the two on the next clock.
- R5: A `sleep_i` strobe in execution goes to sleep mode when `ssby_i` is 0 and the all-stop condition of R6 is false. Sleep mode is left on NMI, on any IRQ, on the 8-bit timer request or on the watchdog request.
- R6: A `sleep_i` strobe goes to module-clock-stop mode when all of these hold: `ssby_i` is 0, `mstp_i` is 16'hFFFF or 16'hFFFE, and `exmstp_i` is 16'hFFFF.
- R7: Module-clock-stop mode is left on NMI, on any IRQ, or on the watchdog request. It is left on the 8-bit timer request only if `mstp_i[0]` is 0; otherwise that request is ignored.
- R8: A `sleep_i` strobe with `ssby_i` at 1 goes to software standby, whatever the stop masks hold. Only NMI, or an `irq_i[k]` whose `irq_stby_en_i[k]` is 1, leaves it.
- R9: A wake returns to the execution mode that `sck_i` selects in the wake cycle. `wake_o` is high for exactly that one cycle, in the same cycle as the new mode.
- R10: `mode_o` is one-hot with these bit positions: 0 reset, 1 high-speed, 2 divided-clock, 3 sleep, 4 module-clock-stop, 5 software standby, 6 hardware standby. `rst_ni` low forces the reset state.
- R11: `cpu_halt_o` is high in every mode except high-speed and divided-clock. `clk_en_o` is high in reset, high-speed, divided-clock and sleep. `reg_rst_o` is high in reset and hardware standby.
- R12: Outside execution, `sleep_i` and changes of `sck_i` do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| res_n_i | input | 1 | Reset pin, active low, asynchronous |
| stby_n_i | input | 1 | Hardware-standby pin, active low, asynchronous |
| sleep_i | input | 1 | Sleep-instruction strobe from the CPU |
| ssby_i | input | 1 | Standby-select bit |
| sck_i | input | 3 | Clock-divide field |
| mstp_i | input | 16 | Module-stop mask |
| exmstp_i | input | 16 | Extended module-stop mask |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_i | input | 16 | External interrupt requests |
| irq_stby_en_i | input | 16 | Per-IRQ enable for waking from software standby |
| tmr8_irq_i | input | 1 | 8-bit timer interrupt request |
| wdt_irq_i | input | 1 | Watchdog interrupt request |
| mode_o | output | 7 | One-hot current mode |
| cpu_halt_o | output | 1 | CPU halt |
| clk_en_o | output | 1 | Module clock enable |
| reg_rst_o | output | 1 | Register-reset request |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
Sleep entry is swept over both standby-bit values and every pairing of five module-stop values with two extended values. This separates the two exact all-stop codes from near misses such as 16'hFFFD and 16'h7FFF. Every wake source (NMI, each of the sixteen IRQs, the timer and the watchdog) is applied alone in each low-power mode. The module-stop bit 0 is tried both set and clear, and the standby-enable mask is tried both empty and patterned, so each mode's wake set is told apart from the others. Pin sequences cover these cases:
- each pin from execution, sleep and standby;
- both pins falling in the same cycle;
- the standby pin released with the reset pin high and with it low.

These fix the priority and the exit route from hardware standby.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int unsigned NUM_MODES = 7;

  localparam int unsigned IDX_RST = 0;
  localparam int unsigned IDX_HS  = 1;
  localparam int unsigned IDX_CD  = 2;
  localparam int unsigned IDX_SLP = 3;
  localparam int unsigned IDX_MCS = 4;
  localparam int unsigned IDX_SWS = 5;
  localparam int unsigned IDX_HWS = 6;

  typedef enum logic [NUM_MODES-1:0] {
    MODE_RST = 7'b000_0001,
    MODE_HS  = 7'b000_0010,
    MODE_CD  = 7'b000_0100,
    MODE_SLP = 7'b000_1000,
    MODE_MCS = 7'b001_0000,
    MODE_SWS = 7'b010_0000,
    MODE_HWS = 7'b100_0000
  } pmode_e;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pm_target_sel.sv
module pm_target_sel
  import pwr_mode_pkg::*;
#(
  parameter int unsigned MSTP_W = 16
) (
  input  logic              ssby_i,
  input  logic [MSTP_W-1:0] mstp_i,
  input  logic [MSTP_W-1:0] exmstp_i,
  output pmode_e            target_o
);
  localparam logic [MSTP_W-1:0] ALL_STOP = {MSTP_W{1'b1}};
  localparam logic [MSTP_W-1:0] ALL_BUT0 = {{(MSTP_W-1){1'b1}}, 1'b0};

  logic all_stop;

  // bit 0 may stay clear so the 8-bit timer keeps running
  assign all_stop = ((mstp_i == ALL_STOP) || (mstp_i == ALL_BUT0)) &&
                    (exmstp_i == ALL_STOP);

  always_comb begin
    if (ssby_i)        target_o = MODE_SWS;
    else if (all_stop) target_o = MODE_MCS;
    else               target_o = MODE_SLP;
  end
endmodule

// File: rtl/pm_wake_eval.sv
module pm_wake_eval #(
  parameter int unsigned N_IRQ = 16
) (
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_stby_en_i,
  input  logic             tmr8_irq_i,
  input  logic             wdt_irq_i,
  input  logic             tmr8_stopped_i,
  output logic             wake_slp_o,
  output logic             wake_mcs_o,
  output logic             wake_sws_o
);
  logic any_irq;
  logic any_en_irq;

  assign any_irq    = |irq_i;
  assign any_en_irq = |(irq_i & irq_stby_en_i);

  assign wake_slp_o = nmi_i | any_irq | tmr8_irq_i | wdt_irq_i;
  assign wake_mcs_o = nmi_i | any_irq | wdt_irq_i | (tmr8_irq_i & ~tmr8_stopped_i);
  assign wake_sws_o = nmi_i | any_en_irq;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_IRQ       = 16,
  parameter int unsigned SCK_W       = 3,
  parameter int unsigned MSTP_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 res_n_i,
  input  logic                 stby_n_i,
  input  logic                 sleep_i,
  input  logic                 ssby_i,
  input  logic [SCK_W-1:0]     sck_i,
  input  logic [MSTP_W-1:0]    mstp_i,
  input  logic [MSTP_W-1:0]    exmstp_i,
  input  logic                 nmi_i,
  input  logic [N_IRQ-1:0]     irq_i,
  input  logic [N_IRQ-1:0]     irq_stby_en_i,
  input  logic                 tmr8_irq_i,
  input  logic                 wdt_irq_i,
  output logic [NUM_MODES-1:0] mode_o,
  output logic                 cpu_halt_o,
  output logic                 clk_en_o,
  output logic                 reg_rst_o,
  output logic                 wake_o
);
  logic       stby_s, res_s;
  logic [1:0] pins_s;

  // reset values: standby released, reset asserted
  pm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stby_n_i, res_n_i}),
    .q_o   (pins_s)
  );
  assign stby_s = pins_s[1];
  assign res_s  = pins_s[0];

  pmode_e target;
  pm_target_sel #(.MSTP_W(MSTP_W)) u_target (
    .ssby_i  (ssby_i),
    .mstp_i  (mstp_i),
    .exmstp_i(exmstp_i),
    .target_o(target)
  );

  logic wake_slp, wake_mcs, wake_sws;
  pm_wake_eval #(.N_IRQ(N_IRQ)) u_wake (
    .nmi_i         (nmi_i),
    .irq_i         (irq_i),
    .irq_stby_en_i (irq_stby_en_i),
    .tmr8_irq_i    (tmr8_irq_i),
    .wdt_irq_i     (wdt_irq_i),
    .tmr8_stopped_i(mstp_i[0]),
    .wake_slp_o    (wake_slp),
    .wake_mcs_o    (wake_mcs),
    .wake_sws_o    (wake_sws)
  );

  pmode_e state_q, state_d, exec_mode;
  logic   wake_d, wake_q;

  assign exec_mode = (sck_i == '0) ? MODE_HS : MODE_CD;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    if (!stby_s) begin
      state_d = MODE_HWS;
    end else if (state_q == MODE_HWS) begin
      if (!res_s) state_d = MODE_RST;
    end else if (!res_s) begin
      state_d = MODE_RST;
    end else begin
      unique case (state_q)
        MODE_RST: state_d = exec_mode;
        MODE_HS, MODE_CD: state_d = sleep_i ? target : exec_mode;
        MODE_SLP: if (wake_slp) begin state_d = exec_mode; wake_d = 1'b1; end
        MODE_MCS: if (wake_mcs) begin state_d = exec_mode; wake_d = 1'b1; end
        MODE_SWS: if (wake_sws) begin state_d = exec_mode; wake_d = 1'b1; end
        default:  state_d = MODE_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_RST;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign mode_o     = state_q;
  assign cpu_halt_o = !(state_q[IDX_HS] || state_q[IDX_CD]);
  assign clk_en_o   = state_q[IDX_RST] || state_q[IDX_HS] || state_q[IDX_CD] ||
                      state_q[IDX_SLP];
  assign reg_rst_o  = state_q[IDX_RST] || state_q[IDX_HWS];
  assign wake_o     = wake_q;
endmodule

// File: rtl/pm_checker.sv
module pm_checker
  import pwr_mode_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sleep_i,
  input logic                 ssby_i,
  input logic [NUM_MODES-1:0] mode_o,
  input logic                 cpu_halt_o,
  input logic                 clk_en_o,
  input logic                 wake_o
);
  logic in_exec, in_lp;
  assign in_exec = mode_o[IDX_HS] | mode_o[IDX_CD];
  assign in_lp   = mode_o[IDX_SLP] | mode_o[IDX_MCS] | mode_o[IDX_SWS];

  p_mode_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);

  p_wake_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  p_wake_from_lp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(in_lp) && in_exec));

  p_hws_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[IDX_HWS] |=> (mode_o[IDX_HWS] || mode_o[IDX_RST]));

  p_rst_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[IDX_RST] |=> (mode_o[IDX_RST] || mode_o[IDX_HWS] ||
                         mode_o[IDX_HS] || mode_o[IDX_CD]));

  p_sws_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[IDX_SWS]) |-> $past(sleep_i && ssby_i && in_exec));

  p_mcs_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[IDX_MCS]) |-> $past(sleep_i && !ssby_i && in_exec));

  p_slp_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[IDX_SLP]) |-> $past(sleep_i && !ssby_i && in_exec));

  p_clk_halt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> cpu_halt_o);
endmodule

bind pwr_mode_ctrl pm_checker u_pm_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .ssby_i    (ssby_i),
  .mode_o    (mode_o),
  .cpu_halt_o(cpu_halt_o),
  .clk_en_o  (clk_en_o),
  .wake_o    (wake_o)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam logic [6:0] M_RST = 7'h01, M_HS = 7'h02, M_CD = 7'h04,
                         M_SLP = 7'h08, M_MCS = 7'h10, M_SWS = 7'h20,
                         M_HWS = 7'h40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        res_n = 1'b0, stby_n = 1'b1, sleep = 1'b0, ssby = 1'b0;
  logic [2:0]  sck = 3'd0;
  logic [15:0] mstp = 16'h0, exmstp = 16'h0, irq = 16'h0, irq_en = 16'h0;
  logic        nmi = 1'b0, tmr8 = 1'b0, wdt = 1'b0;
  logic [6:0]  mode;
  logic        halt, clk_en, reg_rst, wake;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .res_n_i(res_n), .stby_n_i(stby_n),
    .sleep_i(sleep), .ssby_i(ssby), .sck_i(sck), .mstp_i(mstp),
    .exmstp_i(exmstp), .nmi_i(nmi), .irq_i(irq), .irq_stby_en_i(irq_en),
    .tmr8_irq_i(tmr8), .wdt_irq_i(wdt), .mode_o(mode), .cpu_halt_o(halt),
    .clk_en_o(clk_en), .reg_rst_o(reg_rst), .wake_o(wake)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] exec_of(input logic [2:0] s);
    return (s == 3'd0) ? M_HS : M_CD;
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // mode plus the derived outputs (R10, R11)
  task automatic chk_mode(input logic [6:0] exp, input string tag);
    n_chk++;
    if (mode !== exp) begin
      n_err++;
      $display("FAIL %s: mode %b expected %b", tag, mode, exp);
    end
    chk_bit(halt, !(exp == M_HS || exp == M_CD), {tag, " R11 halt"});
    chk_bit(clk_en, (exp == M_RST || exp == M_HS || exp == M_CD || exp == M_SLP),
            {tag, " R11 clk_en"});
    chk_bit(reg_rst, (exp == M_RST || exp == M_HWS), {tag, " R11 reg_rst"});
  endtask

  task automatic do_sleep();
    sleep = 1'b1; step(1); sleep = 1'b0;
  endtask

  task automatic set_src(input int s, input logic v);
    if (s == 0)       nmi = v;
    else if (s <= 16) irq[s-1] = v;
    else if (s == 17) tmr8 = v;
    else              wdt = v;
  endtask

  // m: 0 sleep, 1 module-clock-stop, 2 software standby
  function automatic logic exp_wake(input int m, input int s,
                                    input logic [15:0] ms, input logic [15:0] en);
    if (m == 0) return 1'b1;
    if (m == 1) return (s == 17) ? !ms[0] : 1'b1;
    if (s == 0) return 1'b1;
    if (s <= 16) return en[s-1];
    return 1'b0;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    step(2);
    chk_mode(M_RST, "R10 reset state");
    chk_bit(wake, 1'b0, "R9 no wake in reset");
    rst_ni = 1'b1;
    step(2);
    chk_mode(M_RST, "R2 res pin low holds reset");

    // R4: release reset pin, latency through synchroniser
    res_n = 1'b1;
    step(2);
    chk_mode(M_RST, "R4 sync latency");
    step(1);
    chk_mode(M_HS, "R4 reset to high-speed");

    // R4: clock-divide sweep
    for (int s = 0; s < 8; s++) begin
      sck = 3'(s);
      step(1);
      chk_mode(exec_of(3'(s)), "R4 sck sweep");
    end
    sck = 3'd0; step(1);

    // R5, R6, R8: target sweep
    for (int sb = 0; sb < 2; sb++)
      for (int mi = 0; mi < 5; mi++)
        for (int ei = 0; ei < 2; ei++) begin
          logic [15:0] mv, ev;
          logic [6:0]  tgt;
          mv = (mi == 0) ? 16'h0000 : (mi == 1) ? 16'hFFFF : (mi == 2) ? 16'hFFFE :
               (mi == 3) ? 16'hFFFD : 16'h7FFF;
          ev = (ei == 0) ? 16'hFFFF : 16'h7FFF;
          ssby = sb[0]; mstp = mv; exmstp = ev;
          tgt = sb[0] ? M_SWS :
                (((mv == 16'hFFFF) || (mv == 16'hFFFE)) && ev == 16'hFFFF) ? M_MCS : M_SLP;
          do_sleep();
          chk_mode(tgt, "R5 R6 R8 sleep target");
          // R12: strobe and divide change ignored while halted
          ssby = ~ssby; sck = 3'd3;
          do_sleep();
          step(1);
          chk_mode(tgt, "R12 strobe ignored");
          nmi = 1'b1; step(1); nmi = 1'b0;
          chk_mode(M_CD, "R9 wake to divided mode");
          chk_bit(wake, 1'b1, "R9 wake pulse");
          step(1);
          chk_bit(wake, 1'b0, "R9 wake single cycle");
          sck = 3'd0; step(1);
        end

    // R5, R7, R8, R9: wake-source sweep
    for (int m = 0; m < 3; m++)
      for (int v = 0; v < 2; v++)
        for (int s = 0; s < 19; s++) begin
          logic [6:0] tgt;
          logic       w;
          sck = (s % 2 == 1) ? 3'd5 : 3'd0;
          if (m == 0) begin ssby = 1'b0; mstp = 16'h0; exmstp = 16'h0; tgt = M_SLP; end
          else if (m == 1) begin
            ssby = 1'b0; mstp = (v == 1) ? 16'hFFFE : 16'hFFFF; exmstp = 16'hFFFF; tgt = M_MCS;
          end else begin
            ssby = 1'b1; irq_en = (v == 1) ? 16'hA5A5 : 16'h0000; tgt = M_SWS;
          end
          step(1);
          do_sleep();
          chk_mode(tgt, "R5 R6 R8 enter");
          step(1);
          chk_mode(tgt, "R12 idle stays halted");
          set_src(s, 1'b1); step(1); set_src(s, 1'b0);
          w = exp_wake(m, s, mstp, irq_en);
          if (w) begin
            chk_mode(exec_of(sck), "R7 R8 R9 wake source");
            chk_bit(wake, 1'b1, "R9 wake pulse");
          end else begin
            chk_mode(tgt, "R7 R8 source ignored");
            chk_bit(wake, 1'b0, "R9 no pulse when ignored");
            nmi = 1'b1; step(1); nmi = 1'b0;
            chk_mode(exec_of(sck), "R8 NMI wake");
          end
          step(1);
        end
    ssby = 1'b0; mstp = 16'h0; exmstp = 16'h0; irq_en = 16'h0; sck = 3'd0;
    step(1);

    // R2
    res_n = 1'b0; step(3);
    chk_mode(M_RST, "R2 reset from exec");
    // R1 from reset
    stby_n = 1'b0; step(3);
    chk_mode(M_HWS, "R1 standby from reset");
    // R3 exit with reset low
    stby_n = 1'b1; step(3);
    chk_mode(M_RST, "R3 standby exits to reset");
    res_n = 1'b1; step(3);
    chk_mode(M_HS, "R4 back to exec");
    stby_n = 1'b0; step(3);
    chk_mode(M_HWS, "R1 standby from exec");
    stby_n = 1'b1; step(6);
    chk_mode(M_HWS, "R3 stays with reset high");
    res_n = 1'b0; step(3);
    chk_mode(M_RST, "R3 reset pin leaves standby");
    res_n = 1'b1; step(3);
    chk_mode(M_HS, "R4 exec again");
    // R1 priority: both pins fall together
    res_n = 1'b0; stby_n = 1'b0; step(3);
    chk_mode(M_HWS, "R1 standby beats reset");
    stby_n = 1'b1; step(3);
    chk_mode(M_RST, "R3 exit to reset");
    res_n = 1'b1; step(3);
    // R1 from sleep
    do_sleep();
    chk_mode(M_SLP, "R5 sleep");
    stby_n = 1'b0; step(3);
    chk_mode(M_HWS, "R1 standby from sleep");
    stby_n = 1'b1; res_n = 1'b0; step(3);
    chk_mode(M_RST, "R3 exit");
    res_n = 1'b1; step(3);
    // R2 from software standby
    ssby = 1'b1; do_sleep();
    chk_mode(M_SWS, "R8 software standby");
    res_n = 1'b0; step(3);
    chk_mode(M_RST, "R2 reset from software standby");
    res_n = 1'b1; ssby = 1'b0; step(3);
    chk_mode(M_HS, "R4 final exec");

    summary();
  end
endmodule